// File: doc/BRIEF.md
# Dual-clock decade up/down counter

This block is one decimal digit that counts up or down. It has two count inputs instead of a clock and a direction bit. A rising edge on `count_up` adds one, and a rising edge on `count_dn` subtracts one. A rising edge counts only when the other count input is high at the moment the edge is seen. The block runs on a single system clock. Each count input passes through a synchronizer, and an edge tracker then turns its rising transitions into one-cycle count requests. A level-sensitive preset loads the digit while `load_n` is low. An active-high `clear` overrides everything else.

The active-low `carry_n` and `borrow_n` outputs are built so that several digits chain without extra logic. Connect `carry_n` to the next digit's `count_up` and `borrow_n` to its `count_dn`.
- `carry_n` goes low while the digit shows its top value and `count_up` is low. It rises with `count_up`, so the next digit counts on the same edge that wraps this one.
- `borrow_n` behaves the same way for the digit value zero and `count_dn`.

Each edge tracker is a two-state machine, `ST_LOW` and `ST_HIGH`, following the synchronized input level.
- Transition `ST_LOW -> ST_HIGH` (rise) raises an edge for one cycle.
- Transition `ST_HIGH -> ST_LOW` (fall) and the two self-loops raise nothing.

The digit core picks one operation per clock, in priority order:
1. `OP_CLEAR`
2. `OP_LOAD`
3. `OP_UP` or `OP_DOWN`
4. `OP_HOLD`

Top module: `bcd_updown_counter`

## Requirements
- R1: After reset, `digit` is 0 and both `carry_n` and `borrow_n` are 1. While `clear` is 1, `digit` becomes 0 on the next clock, whatever `load_n`, `preset` and the count inputs are doing.
- R2: While `load_n` is 0 and `clear` is 0, `digit` takes `preset` on each clock and count edges have no effect. Any 4-bit value from 0 to 15 is held exactly as loaded.
- R3: An accepted rising edge on `count_up` increments `digit`. The value 9 wraps to 0.
- R4: An accepted rising edge on `count_dn` decrements `digit`. The value 0 wraps to 9.
- R5: A rising edge on one count input is ignored if the other count input is low when the edge is sampled. If both inputs rise in the same sample, `digit` does not change.
- R6: `carry_n` is 0 exactly while `digit` is 9 and the synchronized `count_up` is 0. Otherwise it is 1.
- R7: `borrow_n` is 0 exactly while `digit` is 0 and the synchronized `count_dn` is 0. Otherwise it is 1.
- R8: From an illegal value (10 to 15), an up count gives 0 and a down count gives 9.
- R9: With no accepted edge, `load_n` at 1 and `clear` at 0, `digit` holds. An accepted edge shows in `digit` by the fourth rising clock edge after the input changes.
- R10: Two digits chained carry-to-up and borrow-to-down count correctly as a two-digit decimal number, including wrapping from 99 to 0 and from 0 to 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_up | input | 1 | Count-up pulse input, idle high |
| count_dn | input | 1 | Count-down pulse input, idle high |
| load_n | input | 1 | Active-low level preset enable |
| clear | input | 1 | Active-high clear to zero |
| preset | input | 4 | Preset value |
| digit | output | 4 | Present count value |
| carry_n | output | 1 | Active-low carry, chains to the next `count_up` |
| borrow_n | output | 1 | Active-low borrow, chains to the next `count_dn` |

## Verification
The bench builds the counter with its default modulus of ten and two synchronizer stages. These are the values at which both wrap points (9 to 0 and 0 to 9) and the illegal preset range from 10 to 15 can be reached through the 4-bit preset. A second pair of default instances, chained carry-to-up and borrow-to-down, brings the two-digit wrap between 99 and 0 within reach. With two synchronizer stages, the latency from a count-input change to `digit` is short enough for the bench to wait a fixed four clocks after each change.

// File: rtl/bcd_updown_pkg.sv
package bcd_updown_pkg;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } edge_state_t;

    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_UP    = 3'd1,
        OP_DOWN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4
    } count_op_t;

endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
    parameter int  STAGES    = 2,
    parameter int  WIDTH     = 1,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= {WIDTH{RESET_VAL}};
                else        chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= {WIDTH{RESET_VAL}};
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/bcd_edge_fsm.sv
module bcd_edge_fsm
    import bcd_updown_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic other_level,
    output logic accept
);

    edge_state_t state, state_nx;
    logic        rise;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOW:  state_nx = level ? ST_HIGH : ST_LOW;
            ST_HIGH: state_nx = level ? ST_HIGH : ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HIGH;
        else        state <= state_nx;
    end

    always_comb begin
        rise   = 1'b0;
        accept = 1'b0;
        unique case (state)
            ST_LOW: begin
                rise   = level;
                accept = level && other_level;
            end
            ST_HIGH: begin
                rise   = 1'b0;
                accept = 1'b0;
            end
        endcase
    end

    // R5: an accepted edge never lasts more than one cycle
    p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    // R5: a rise is never accepted while the other input is low
    p_gate_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !other_level) |-> !accept);

endmodule

// File: rtl/bcd_digit_core.sv
module bcd_digit_core
    import bcd_updown_pkg::*;
#(
    parameter int MODULUS = 10,
    parameter int W       = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load_n,
    input  logic [W-1:0] preset,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] digit
);

    localparam logic [W-1:0] TOP_VAL = W'(MODULUS - 1);

    count_op_t    op;
    logic [W-1:0] digit_nx;

    always_comb begin
        if (clear)             op = OP_CLEAR;
        else if (!load_n)      op = OP_LOAD;
        else if (inc && !dec)  op = OP_UP;
        else if (dec && !inc)  op = OP_DOWN;
        else                   op = OP_HOLD;
    end

    always_comb begin
        digit_nx = digit;
        unique case (op)
            OP_CLEAR: digit_nx = '0;
            OP_LOAD:  digit_nx = preset;
            OP_UP:    digit_nx = (digit >= TOP_VAL) ? '0 : digit + 1'b1;
            OP_DOWN:  digit_nx = (digit == '0 || digit > TOP_VAL) ? TOP_VAL
                                                                  : digit - 1'b1;
            OP_HOLD:  digit_nx = digit;
            default:  digit_nx = digit;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) digit <= '0;
        else        digit <= digit_nx;
    end

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (digit == '0));

    p_load_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_n) |=> (digit == $past(preset)));

    p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && inc && !dec && digit == TOP_VAL) |=> (digit == '0));

    p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && dec && !inc && digit == '0) |=> (digit == TOP_VAL));

    p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && inc && dec) |=> $stable(digit));

    p_illegal_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && inc && !dec && digit > TOP_VAL) |=> (digit == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && load_n && !inc && !dec) |=> $stable(digit));

endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
    import bcd_updown_pkg::*;
#(
    parameter int MODULUS     = 10,
    parameter int SYNC_STAGES = 2,
    parameter int W           = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_up,
    input  logic         count_dn,
    input  logic         load_n,
    input  logic         clear,
    input  logic [W-1:0] preset,
    output logic [W-1:0] digit,
    output logic         carry_n,
    output logic         borrow_n
);

    localparam logic [W-1:0] TOP_VAL = W'(MODULUS - 1);

    logic [1:0] cnt_raw, cnt_s;
    logic       up_s, dn_s, up_acc, dn_acc;

    assign cnt_raw = {count_dn, count_up};

    bcd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cnt_raw),
        .dout (cnt_s)
    );

    assign up_s = cnt_s[0];
    assign dn_s = cnt_s[1];

    bcd_edge_fsm u_up_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (up_s),
        .other_level(dn_s),
        .accept     (up_acc)
    );

    bcd_edge_fsm u_dn_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (dn_s),
        .other_level(up_s),
        .accept     (dn_acc)
    );

    bcd_digit_core #(.MODULUS(MODULUS), .W(W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .load_n(load_n),
        .preset(preset),
        .inc   (up_acc),
        .dec   (dn_acc),
        .digit (digit)
    );

    assign carry_n  = !((digit == TOP_VAL) && !up_s);
    assign borrow_n = !((digit == '0) && !dn_s);

    p_carry_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_s |-> carry_n);

    p_borrow_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_s |-> borrow_n);

    // R3: a carry release while counting up at the top is followed by a zero digit
    p_carry_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(carry_n) && up_acc && !dn_acc && load_n && !clear) |=> (digit == '0));

endmodule

// File: tb/bcd_updown_counter_bench.sv
`timescale 1ns/1ps
module bcd_updown_counter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       count_up = 1'b1, count_dn = 1'b1, load_n = 1'b1, clear = 1'b0;
    logic [3:0] preset = 4'd0;
    logic [3:0] digit;
    logic       carry_n, borrow_n;

    logic       lo_up = 1'b1, lo_dn = 1'b1;
    logic [3:0] lo_q, hi_q;
    logic       lo_c, lo_b, hi_c, hi_b;

    int n_chk = 0;
    int n_fail = 0;
    int model = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_updown_counter u_bcd_updown_counter (
        .clk(clk), .rst_n(rst_n), .count_up(count_up), .count_dn(count_dn),
        .load_n(load_n), .clear(clear), .preset(preset),
        .digit(digit), .carry_n(carry_n), .borrow_n(borrow_n)
    );

    bcd_updown_counter u_lo (
        .clk(clk), .rst_n(rst_n), .count_up(lo_up), .count_dn(lo_dn),
        .load_n(1'b1), .clear(1'b0), .preset(4'd0),
        .digit(lo_q), .carry_n(lo_c), .borrow_n(lo_b)
    );

    bcd_updown_counter u_hi (
        .clk(clk), .rst_n(rst_n), .count_up(lo_c), .count_dn(lo_b),
        .load_n(1'b1), .clear(1'b0), .preset(4'd0),
        .digit(hi_q), .carry_n(hi_c), .borrow_n(hi_b)
    );

    function automatic int f_up(input int v);
        return (v >= 9) ? 0 : v + 1;
    endfunction

    function automatic int f_dn(input int v);
        return (v == 0 || v > 9) ? 9 : v - 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_up();
        @(negedge clk) count_up = 1'b0;
        tick(4);
        chk("R6 carry during low up", int'(carry_n), (model == 9) ? 0 : 1);
        @(negedge clk) count_up = 1'b1;
        tick(4);
        model = f_up(model);
        chk("R3 up count", int'(digit), model);
        chk("R6 carry idle", int'(carry_n), 1);
    endtask

    task automatic pulse_dn();
        @(negedge clk) count_dn = 1'b0;
        tick(4);
        chk("R7 borrow during low down", int'(borrow_n), (model == 0) ? 0 : 1);
        @(negedge clk) count_dn = 1'b1;
        tick(4);
        model = f_dn(model);
        chk("R4 down count", int'(digit), model);
        chk("R7 borrow idle", int'(borrow_n), 1);
    endtask

    task automatic do_load(input int v);
        @(negedge clk) begin load_n = 1'b0; preset = 4'(v); end
        tick(2);
        chk("R2 load value", int'(digit), v);
        @(negedge clk) count_up = 1'b0;
        tick(4);
        @(negedge clk) count_up = 1'b1;
        tick(4);
        chk("R2 load overrides count", int'(digit), v);
        @(negedge clk) load_n = 1'b1;
        model = v;
        tick(2);
        chk("R2 held after load", int'(digit), v);
    endtask

    task automatic do_clear();
        @(negedge clk) begin clear = 1'b1; load_n = 1'b0; preset = 4'd7; end
        tick(2);
        chk("R1 clear overrides load", int'(digit), 0);
        @(negedge clk) begin clear = 1'b0; load_n = 1'b1; end
        model = 0;
        tick(2);
        chk("R1 clear result", int'(digit), 0);
    endtask

    task automatic ignored_up();
        @(negedge clk) count_dn = 1'b0;
        tick(4);
        @(negedge clk) count_up = 1'b0;
        tick(4);
        @(negedge clk) count_up = 1'b1;
        tick(4);
        chk("R5 up ignored while down low", int'(digit), model);
        @(negedge clk) count_dn = 1'b1;
        tick(4);
        model = f_dn(model);
        chk("R5 down edge with up high", int'(digit), model);
    endtask

    task automatic both_rise();
        @(negedge clk) begin count_up = 1'b0; count_dn = 1'b0; end
        tick(4);
        @(negedge clk) begin count_up = 1'b1; count_dn = 1'b1; end
        tick(4);
        chk("R5 simultaneous edges hold", int'(digit), model);
    endtask

    task automatic casc_up();
        @(negedge clk) lo_up = 1'b0;
        tick(8);
        @(negedge clk) lo_up = 1'b1;
        tick(8);
    endtask

    task automatic casc_dn();
        @(negedge clk) lo_dn = 1'b0;
        tick(8);
        @(negedge clk) lo_dn = 1'b1;
        tick(8);
    endtask

    initial begin
        #700000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'h5eed_0192));
        tick(3);
        @(negedge clk) rst_n = 1'b1;
        tick(2);
        chk("R1 reset digit", int'(digit), 0);
        chk("R1 reset carry", int'(carry_n), 1);
        chk("R7 borrow idle at zero", int'(borrow_n), 1);

        // Directed corner cases
        pulse_dn();                       // R4 0 wraps to 9
        pulse_up();                       // R3 9 wraps to 0
        do_load(9);
        pulse_up();                       // R6 carry low at 9
        do_load(12);
        pulse_up();                       // R8 illegal up goes to 0
        do_load(15);
        pulse_dn();                       // R8 illegal down goes to 9
        do_load(10);
        pulse_dn();                       // R8 illegal down goes to 9
        ignored_up();
        both_rise();
        do_clear();
        tick(10);
        chk("R9 hold without edges", int'(digit), model);

        // Constrained random sequence
        for (int i = 0; i < 250; i++) begin
            r = int'($urandom % 10);
            if (r < 4)       pulse_up();
            else if (r < 7)  pulse_dn();
            else if (r == 7) do_load(int'($urandom % 16));
            else if (r == 8) ignored_up();
            else if ($urandom % 2 == 0) both_rise();
            else do_clear();
        end

        // Two-digit chain
        for (int i = 0; i < 25; i++) casc_up();
        chk("R10 chain up to 25", int'(lo_q) + 10 * int'(hi_q), 25);
        for (int i = 0; i < 30; i++) casc_dn();
        chk("R10 chain down wraps to 95", int'(lo_q) + 10 * int'(hi_q), 95);
        for (int i = 0; i < 5; i++) casc_up();
        chk("R10 chain up wraps to 0", int'(lo_q) + 10 * int'(hi_q), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule